// File: doc/BRIEF.md
# Serial Loader Entry and Autobaud Detector

This block decides whether a device that is being held in reset should enter its serial program-load mode, and then finds the bit rate used by the host. It watches three static inputs: the device reset pin, an active-low program-store strobe, and two port strap pins. The strobe must be pulled low only after reset is already high. Both straps high choose the serial loader. Any other strap value chooses the parallel path, and the block then only reports that choice.

Once serial mode is armed, the block watches the receive line. It measures the low time of each start bit in clock cycles and compares it with four candidate bit times. When the length fits one of them, it samples the eight data bits at mid-bit and checks them against a carriage return. On a match, it locks a two-bit rate code and a divisor that a companion UART uses. These values stay fixed until the device reset pin is released. The link has only a receive line, a transmit line and ground, so the block uses no handshake signals.

Top module: `serial_boot_autobaud`

## Requirements
- R1: While `rst` is high, and in the cycle after it, every output is 0.
- R2: Serial mode is entered under these conditions:
  - `dev_reset_i` is 1 and `store_strobe_n_i` is seen high.
  - `store_strobe_n_i` then falls while `dev_reset_i` is still 1.
  - Both bits of `strap_i` are 1 at the moment of entry.
  
  When this happens, `serial_mode_o` goes to 1 within 4 cycles.
- R3: If `store_strobe_n_i` is already 0 when `dev_reset_i` rises, neither mode is entered. Entry needs the strobe to go high and then fall again while reset is held.
- R4: If either bit of `strap_i` is 0 at entry, `parallel_mode_o` goes to 1 and `serial_mode_o` stays 0. No rate is then locked, whatever the receive line carries.
- R5: Each frame has these parts:
  - a low start bit;
  - eight data bits, least significant bit first;
  - a high stop bit.
  
  A carriage return (0x0D) sent at one of the four rates sets `baud_locked_o`. `baud_code_o` then shows the rate: 0 = 300, 1 = 1200, 2 = 2400, 3 = 9600 bit/s. `baud_div_o` equals CLK_HZ divided by that rate.
- R6: A start bit whose low time falls outside ±TOL_PCT percent of every candidate bit time is rejected. Detection then goes back to hunting, and a later valid carriage return still locks.
- R7: A byte with a valid start bit but data other than 0x0D does not lock. The block then hunts for the next start bit.
- R8: Once locked, the code and divisor do not change while `dev_reset_i` stays high, whatever the receive line carries.
- R9: When `dev_reset_i` goes low, both mode outputs, the lock, the code and the divisor return to 0.
- R10: Traffic on the receive line before serial mode is entered has no effect on the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| dev_reset_i | input | 1 | Device reset pin being observed, active high |
| store_strobe_n_i | input | 1 | Program-store strobe, active low |
| strap_i | input | 2 | Port strap pins; both high selects serial loading |
| rxd_i | input | 1 | Asynchronous receive line, idles high |
| serial_mode_o | output | 1 | Serial load mode armed |
| parallel_mode_o | output | 1 | Parallel load path selected |
| baud_locked_o | output | 1 | A carriage return was recognised and the rate is locked |
| baud_code_o | output | 2 | Locked rate code |
| baud_div_o | output | DIV_W | Bit time of the locked rate, in clock cycles |

## Verification
The assertions assume three things about the inputs:
- The reset pin, the strobe and the straps are quasi-static: each stays put for many clocks after a change.
- The receive line idles high between frames.
- The clock parameter gives well-separated tolerance windows for the four rates.

The stimulus holds each strap and strobe level for several cycles before the next change. Every frame ends with at least one full idle bit time. The bench sets the clock parameter so that the four bit times are 640, 160, 80 and 20 cycles. Misframed bytes are timed so that the misaligned bit that follows still lands inside a window.

// File: rtl/sba_pkg.sv
package sba_pkg;
  localparam int NRATES = 4;
  localparam logic [7:0] CR_CHAR = 8'h0D;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_HUNT = 3'd1,
    S_MEAS = 3'd2,
    S_DATA = 3'd3,
    S_LOCK = 3'd4
  } hunt_st_e;

  // rate code to bit/s
  function automatic int rate_baud(input int idx);
    case (idx)
      0:       return 300;
      1:       return 1200;
      2:       return 2400;
      default: return 9600;
    endcase
  endfunction

  function automatic int bit_cycles(input int clk_hz, input int idx);
    return clk_hz / rate_baud(idx);
  endfunction
endpackage

// File: rtl/sba_sync.sv
module sba_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/sba_entry.sv
module sba_entry (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_s,
  input  logic       strobe_n_s,
  input  logic [1:0] strap_s,
  output logic       ser_mode,
  output logic       par_mode
);
  logic order_ok;
  logic entered;

  assign entered = ser_mode | par_mode;

  always_ff @(posedge clk) begin
    if (rst || !hold_s) begin
      order_ok <= 1'b0;
      ser_mode <= 1'b0;
      par_mode <= 1'b0;
    end else if (!entered) begin
      if (strobe_n_s) order_ok <= 1'b1;
      if (order_ok && !strobe_n_s) begin
        if (&strap_s) ser_mode <= 1'b1;
        else          par_mode <= 1'b1;
      end
    end
  end

  // R2: a mode is only entered from reset held with the strobe low
  assert_entry_cond_R2: assert property (@(posedge clk) disable iff (rst)
    (entered && !$past(entered)) |-> $past(hold_s && !strobe_n_s));

  // R4: serial mode only appears with both straps high
  assert_strap_serial_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_mode) |-> $past(&strap_s));

  // R9: releasing the reset pin drops any mode
  assert_release_clears_R9: assert property (@(posedge clk) disable iff (rst)
    !hold_s |=> !entered);
endmodule

// File: rtl/sba_classify.sv
module sba_classify import sba_pkg::*; #(
  parameter int CLK_HZ  = 11_059_200,
  parameter int TOL_PCT = 6,
  parameter int CNT_W   = 16
) (
  input  logic [CNT_W-1:0] len,
  output logic             hit,
  output logic [1:0]       idx
);
  logic [NRATES-1:0] win;

  for (genvar i = 0; i < NRATES; i++) begin : g_win
    localparam int BT = bit_cycles(CLK_HZ, i);
    localparam int DT = BT * TOL_PCT / 100;
    assign win[i] = (len >= CNT_W'(BT - DT)) && (len <= CNT_W'(BT + DT));
  end

  always_comb begin
    hit = |win;
    idx = 2'd0;
    for (int i = 0; i < NRATES; i++) begin
      if (win[i]) idx = 2'(i);
    end
  end
endmodule

// File: rtl/sba_hunt.sv
module sba_hunt import sba_pkg::*; #(
  parameter int CLK_HZ  = 11_059_200,
  parameter int TOL_PCT = 6,
  parameter int DIV_W   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             rx,
  output logic             locked,
  output logic [1:0]       code,
  output logic [DIV_W-1:0] div
);
  localparam int BT_SLOW = bit_cycles(CLK_HZ, 0);
  localparam int LIMIT   = BT_SLOW + BT_SLOW * TOL_PCT / 100 + 1;
  localparam int CNT_W   = $clog2(LIMIT + 1);

  hunt_st_e         st;
  logic [CNT_W-1:0] cnt;
  logic [DIV_W-1:0] timer;
  logic [2:0]       bitn;
  logic [7:0]       sh;
  logic [7:0]       nxt;
  logic [1:0]       sel;
  logic             hit;
  logic [1:0]       hit_idx;

  function automatic logic [DIV_W-1:0] bt_of(input logic [1:0] s);
    logic [DIV_W-1:0] r;
    r = '0;
    for (int k = 0; k < NRATES; k++) begin
      if (s == 2'(k)) r = DIV_W'(bit_cycles(CLK_HZ, k));
    end
    return r;
  endfunction

  sba_classify #(.CLK_HZ(CLK_HZ), .TOL_PCT(TOL_PCT), .CNT_W(CNT_W)) u_cls (
    .len(cnt),
    .hit(hit),
    .idx(hit_idx)
  );

  assign nxt = {rx, sh[7:1]};

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      st     <= S_IDLE;
      cnt    <= '0;
      timer  <= '0;
      bitn   <= '0;
      sh     <= '0;
      sel    <= '0;
      locked <= 1'b0;
      code   <= '0;
      div    <= '0;
    end else begin
      case (st)
        S_IDLE: if (rx) st <= S_HUNT;
        S_HUNT: begin
          if (!rx) begin
            st  <= S_MEAS;
            cnt <= CNT_W'(1);
          end
        end
        S_MEAS: begin
          if (!rx) begin
            if (cnt == CNT_W'(LIMIT)) st <= S_IDLE;
            else                      cnt <= cnt + 1'b1;
          end else if (hit) begin
            st    <= S_DATA;
            sel   <= hit_idx;
            timer <= (bt_of(hit_idx) >> 1) - 1'b1;
            bitn  <= '0;
          end else begin
            st <= S_IDLE;
          end
        end
        S_DATA: begin
          if (timer == '0) begin
            sh    <= nxt;
            timer <= bt_of(sel) - 1'b1;
            bitn  <= bitn + 1'b1;
            if (bitn == 3'd7) begin
              if (nxt == CR_CHAR) begin
                st     <= S_LOCK;
                locked <= 1'b1;
                code   <= sel;
                div    <= bt_of(sel);
              end else begin
                st <= S_IDLE;
              end
            end
          end else begin
            timer <= timer - 1'b1;
          end
        end
        S_LOCK: st <= S_LOCK;
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: the start-bit counter never runs past its abort limit
  assert_meas_bounded_R6: assert property (@(posedge clk) disable iff (rst)
    (st == S_MEAS) |-> (cnt <= CNT_W'(LIMIT)));

  // R8: locked rate and divisor hold still
  assert_lock_stable_R8: assert property (@(posedge clk) disable iff (rst)
    (locked && $past(locked)) |-> ($stable(code) && $stable(div)));

  // R10: a lock can only appear while serial mode is armed
  assert_lock_needs_mode_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(enable));

  // R5: a locked divisor is never zero
  assert_div_nonzero_R5: assert property (@(posedge clk) disable iff (rst)
    locked |-> (div != '0));
endmodule

// File: rtl/serial_boot_autobaud.sv
module serial_boot_autobaud import sba_pkg::*; #(
  parameter int CLK_HZ      = 11_059_200,
  parameter int TOL_PCT     = 6,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_W       = $clog2(CLK_HZ / 300 + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dev_reset_i,
  input  logic             store_strobe_n_i,
  input  logic [1:0]       strap_i,
  input  logic             rxd_i,
  output logic             serial_mode_o,
  output logic             parallel_mode_o,
  output logic             baud_locked_o,
  output logic [1:0]       baud_code_o,
  output logic [DIV_W-1:0] baud_div_o
);
  localparam int IN_W = 5;

  logic [IN_W-1:0] raw_in;
  logic [IN_W-1:0] syn_in;
  logic            ser_mode;
  logic            par_mode;

  // {rx, reset pin, strobe_n, straps}; idle values after reset
  assign raw_in = {rxd_i, dev_reset_i, store_strobe_n_i, strap_i};

  sba_sync #(.W(IN_W), .STAGES(SYNC_STAGES), .INIT(5'b10100)) u_sync (
    .clk(clk),
    .rst(rst),
    .d(raw_in),
    .q(syn_in)
  );

  sba_entry u_entry (
    .clk(clk),
    .rst(rst),
    .hold_s(syn_in[3]),
    .strobe_n_s(syn_in[2]),
    .strap_s(syn_in[1:0]),
    .ser_mode(ser_mode),
    .par_mode(par_mode)
  );

  sba_hunt #(.CLK_HZ(CLK_HZ), .TOL_PCT(TOL_PCT), .DIV_W(DIV_W)) u_hunt (
    .clk(clk),
    .rst(rst),
    .enable(ser_mode),
    .rx(syn_in[4]),
    .locked(baud_locked_o),
    .code(baud_code_o),
    .div(baud_div_o)
  );

  assign serial_mode_o   = ser_mode;
  assign parallel_mode_o = par_mode;
endmodule

// File: tb/tb_serial_boot_autobaud.sv
module tb_serial_boot_autobaud;
  localparam int CLK_HZ = 192_000;
  localparam int DIV_W  = $clog2(CLK_HZ / 300 + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             dev_reset = 1'b0;
  logic             strobe_n = 1'b1;
  logic [1:0]       strap = 2'b11;
  logic             rxd = 1'b1;
  logic             ser_o, par_o, lock_o;
  logic [1:0]       code_o;
  logic [DIV_W-1:0] div_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  serial_boot_autobaud #(.CLK_HZ(CLK_HZ), .TOL_PCT(6)) dut (
    .clk(clk), .rst(rst), .dev_reset_i(dev_reset), .store_strobe_n_i(strobe_n),
    .strap_i(strap), .rxd_i(rxd), .serial_mode_o(ser_o), .parallel_mode_o(par_o),
    .baud_locked_o(lock_o), .baud_code_o(code_o), .baud_div_o(div_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; dev_reset = 1'b0; strobe_n = 1'b1; strap = 2'b11; rxd = 1'b1;
    cyc(4);
    rst = 1'b0;
    cyc(2);
  endtask

  task automatic enter(input logic [1:0] s);
    strap = s;
    dev_reset = 1'b1;
    cyc(5);
    strobe_n = 1'b0;
    cyc(6);
  endtask

  task automatic send_byte(input logic [7:0] d, input int bt, input int start_len);
    rxd = 1'b0;
    cyc(start_len);
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      cyc(bt);
    end
    rxd = 1'b1;
    cyc(2 * bt + 4);
  endtask

  function automatic int out_word();
    return {lock_o, code_o, ser_o, par_o} ;
  endfunction

  // R1
  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    cyc(2);
    check(out_word() == 0 && div_o == 0, "R1 outputs in reset", out_word(), 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_word() == 0 && div_o == 0, "R1 outputs after reset", out_word(), 0);
  endtask

  // R2
  task automatic t_entry();
    do_reset();
    enter(2'b11);
    check(ser_o == 1 && par_o == 0, "R2 serial entry", {ser_o, par_o}, 2);
    check(lock_o == 0, "R2 no lock before char", lock_o, 0);
  endtask

  // R5: one carriage return per rate
  task automatic t_rate(input int code, input int baud);
    int bt;
    bt = CLK_HZ / baud;
    do_reset();
    enter(2'b11);
    send_byte(8'h0D, bt, bt);
    check(lock_o == 1, "R5 lock", lock_o, 1);
    check(code_o == code, "R5 code", code_o, code);
    check(div_o == bt, "R5 divisor", div_o, bt);
  endtask

  // R3
  task automatic t_order();
    do_reset();
    strobe_n = 1'b0;
    cyc(3);
    dev_reset = 1'b1;
    cyc(10);
    check(ser_o == 0 && par_o == 0, "R3 wrong order no entry", {ser_o, par_o}, 0);
    strobe_n = 1'b1;
    cyc(5);
    strobe_n = 1'b0;
    cyc(6);
    check(ser_o == 1, "R3 entry after re-pull", ser_o, 1);
  endtask

  // R4
  task automatic t_parallel();
    do_reset();
    enter(2'b10);
    check(par_o == 1 && ser_o == 0, "R4 parallel chosen", {ser_o, par_o}, 1);
    strap = 2'b11;
    cyc(5);
    check(par_o == 1 && ser_o == 0, "R4 straps latched", {ser_o, par_o}, 1);
    send_byte(8'h0D, 20, 20);
    check(lock_o == 0, "R4 no lock in parallel", lock_o, 0);
  endtask

  // R6
  task automatic t_badlen();
    do_reset();
    enter(2'b11);
    send_byte(8'h0D, 20, 23);
    check(lock_o == 0, "R6 long start rejected", lock_o, 0);
    send_byte(8'h0D, 20, 17);
    check(lock_o == 0, "R6 short start rejected", lock_o, 0);
    send_byte(8'h0D, 20, 20);
    check(lock_o == 1 && code_o == 3, "R6 later CR locks", {lock_o, code_o}, 7);
  endtask

  // R7
  task automatic t_badchar();
    do_reset();
    enter(2'b11);
    send_byte(8'h0F, 80, 80);
    check(lock_o == 0, "R7 wrong char no lock", lock_o, 0);
    send_byte(8'h0D, 80, 80);
    check(lock_o == 1 && code_o == 2, "R7 hunt resumes", {lock_o, code_o}, 6);
  endtask

  // R8 and R9
  task automatic t_hold_release();
    do_reset();
    enter(2'b11);
    send_byte(8'h0D, 20, 20);
    send_byte(8'h0D, 80, 80);
    send_byte(8'h55, 20, 20);
    check(lock_o == 1 && code_o == 3, "R8 code held", {lock_o, code_o}, 7);
    check(div_o == 20, "R8 divisor held", div_o, 20);
    dev_reset = 1'b0;
    cyc(5);
    check(out_word() == 0 && div_o == 0, "R9 release clears", out_word(), 0);
  endtask

  // R10
  task automatic t_ignore();
    do_reset();
    send_byte(8'h0D, 20, 20);
    dev_reset = 1'b1;
    cyc(5);
    send_byte(8'h0D, 20, 20);
    check(lock_o == 0 && ser_o == 0, "R10 traffic before entry", {lock_o, ser_o}, 0);
    strobe_n = 1'b0;
    cyc(6);
    check(lock_o == 0 && ser_o == 1, "R10 no stale lock", {lock_o, ser_o}, 1);
  endtask

  initial begin
    t_reset();
    t_entry();
    t_rate(0, 300);
    t_rate(1, 1200);
    t_rate(2, 2400);
    t_rate(3, 9600);
    t_order();
    t_parallel();
    t_badlen();
    t_badchar();
    t_hold_release();
    t_ignore();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule